// File: doc/BRIEF.md
# USB Device Interrupt Flags and Suspend Detector

This block holds the eight interrupt flags of a low-speed USB device controller and decides when a long bus-idle period means the host wants the device to suspend. Other parts of the controller handle the serial engine, the CRC and bit-stuffing checks, the DMA engine and the endpoint bookkeeping. They deliver one-cycle event pulses, already qualified, to this block. Each pulse latches its flag. Firmware reads all eight flags at once over a plain register port. It acknowledges a flag by writing a zero to that flag's bit. The block drives one interrupt line that stays high while any flag is set.

A cycle counter watches the level of the idle line. Counting is enabled by the first bus reset event. Once enabled, the suspend flag is raised after the bus has been idle for the configured time: 3 ms, which is 24000 cycles of an 8 MHz clock. Any bus activity restarts the count. While firmware forces the device into suspend, the check is blocked. It stays blocked until the controller signals that the resume sequence has finished.

Top module: `usb_irq_status`

## Requirements
- R1: While reset is asserted, and right after it, the flag register reads 00h and `irq` is low.
- R2: Flag positions are: bit 0 frame start, bit 1 bus reset, bit 2 expected suspend, bit 3 interrupt overrun, bit 4 error, bit 5 correct transfer, bit 6 DMA over/underrun, bit 7 suspend. A pulse on an event input sets its bit at the next clock edge.
- R3: A register write never changes a bit from 0 to 1.
- R4: A write clears every bit where `wr_data` holds 0 and keeps every bit where it holds 1.
- R5: When a hardware set and a software clear of the same bit fall in the same cycle, the bit ends up set.
- R6: An error pulse while bit 4 is already set, or a frame-start pulse while bit 0 is already set, also sets bit 3. A first error or frame-start pulse does not set bit 3.
- R7: Bit 5 is set only by `xfer_done` when `xfer_refused` is low in the same cycle. A transfer answered with NAK or STALL does not set it.
- R8: After a bus reset pulse has armed the check, bit 7 is set at the edge that completes IDLE_CYCLES consecutive cycles with `bus_idle` high. Here IDLE_CYCLES = CLK_HZ/1000*IDLE_US/1000. Before any bus reset, idle time never sets bit 7.
- R9: A single cycle with `bus_idle` low restarts the idle count from zero.
- R10: While `force_susp` is high, and after it drops until a `resume_done` pulse, idle time does not set bit 7.
- R11: `irq` is high exactly when at least one flag bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_sof | input | 1 | Frame-start event pulse |
| ev_bus_reset | input | 1 | Bus reset event pulse; also arms the idle check |
| ev_esusp | input | 1 | Expected-suspend event pulse |
| ev_error | input | 1 | Timeout, CRC, bit-stuffing or framing error pulse |
| xfer_done | input | 1 | Transfer completed without any protocol error |
| xfer_refused | input | 1 | The completed transfer was answered with NAK or STALL |
| ev_dma_late | input | 1 | DMA request was not serviced in time |
| bus_idle | input | 1 | Bus line is in the idle state this cycle |
| force_susp | input | 1 | Firmware is forcing suspend |
| resume_done | input | 1 | Pulse at the end of the resume sequence |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 0 bit clears the flag at that position |
| rd_data | output | 8 | Current flag register |
| irq | output | 1 | OR of all flags |

## Verification
The assertions take the event inputs to be single-cycle pulses that are already qualified. They also take `resume_done` to arrive only after `force_susp` has dropped. The properties on clearing and on writes that never set a bit apply only in cycles with no event input active. The bench keeps to these conditions: it raises every event for exactly one cycle, and it issues `resume_done` only once forced suspend has ended. It drives `bus_idle` low at all times except in the timer scenarios, so no stray suspend flag appears during the flag tests.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
    localparam int FLAG_W    = 8;
    localparam int B_SOF     = 0;
    localparam int B_BRESET  = 1;
    localparam int B_ESUSP   = 2;
    localparam int B_OVR     = 3;
    localparam int B_ERR     = 4;
    localparam int B_XFER    = 5;
    localparam int B_DMA     = 6;
    localparam int B_SUSP    = 7;

    typedef logic [FLAG_W-1:0] flags_t;
endpackage

// File: rtl/usb_idle_timer.sv
module usb_idle_timer #(
    parameter int IDLE_CYCLES = 24000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_idle,
    input  logic bus_reset,
    input  logic force_susp,
    input  logic resume_done,
    output logic susp_pulse
);
    localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LIMIT     = CNT_W'(IDLE_CYCLES);
    localparam logic [CNT_W-1:0] LIMIT_M1  = CNT_W'(IDLE_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             hold;
    } tmr_t;

    tmr_t st_d, st_q;
    logic active;

    always_comb begin
        st_d       = st_q;
        active     = st_q.armed && !st_q.hold && !force_susp;
        susp_pulse = 1'b0;

        if (bus_reset)
            st_d.armed = 1'b1;

        if (force_susp)
            st_d.hold = 1'b1;
        else if (resume_done)
            st_d.hold = 1'b0;

        if (!active || !bus_idle) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LIMIT_M1)
                susp_pulse = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end
endmodule

// File: rtl/usb_event_map.sv
module usb_event_map
    import usb_irq_pkg::*;
(
    input  flags_t cur_flags,
    input  logic   ev_sof,
    input  logic   ev_bus_reset,
    input  logic   ev_esusp,
    input  logic   ev_error,
    input  logic   xfer_done,
    input  logic   xfer_refused,
    input  logic   ev_dma_late,
    input  logic   susp_pulse,
    output flags_t set_vec
);
    always_comb begin
        set_vec           = '0;
        set_vec[B_SOF]    = ev_sof;
        set_vec[B_BRESET] = ev_bus_reset;
        set_vec[B_ESUSP]  = ev_esusp;
        set_vec[B_ERR]    = ev_error;
        set_vec[B_XFER]   = xfer_done && !xfer_refused;
        set_vec[B_DMA]    = ev_dma_late;
        set_vec[B_SUSP]   = susp_pulse;
        set_vec[B_OVR]    = (ev_error && cur_flags[B_ERR])
                          || (ev_sof && cur_flags[B_SOF]);
    end
endmodule

// File: rtl/usb_flag_bank.sv
module usb_flag_bank
    import usb_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  flags_t set_vec,
    input  logic   wr_en,
    input  flags_t wr_data,
    output flags_t flags
);
    flags_t flags_d, flags_q;
    flags_t keep_mask;

    always_comb begin
        keep_mask = wr_en ? wr_data : '1;
        flags_d   = (flags_q & keep_mask) | set_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= flags_d;
    end

    assign flags = flags_q;
endmodule

// File: rtl/usb_irq_status.sv
module usb_irq_status
    import usb_irq_pkg::*;
#(
    parameter int CLK_HZ  = 8_000_000,
    parameter int IDLE_US = 3000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ev_sof,
    input  logic       ev_bus_reset,
    input  logic       ev_esusp,
    input  logic       ev_error,
    input  logic       xfer_done,
    input  logic       xfer_refused,
    input  logic       ev_dma_late,
    input  logic       bus_idle,
    input  logic       force_susp,
    input  logic       resume_done,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       irq
);
    localparam int IDLE_CYCLES = (CLK_HZ / 1000) * IDLE_US / 1000;

    logic   susp_pulse;
    flags_t set_vec;
    flags_t flags;

    usb_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_idle    (bus_idle),
        .bus_reset   (ev_bus_reset),
        .force_susp  (force_susp),
        .resume_done (resume_done),
        .susp_pulse  (susp_pulse)
    );

    usb_event_map u_map (
        .cur_flags    (flags),
        .ev_sof       (ev_sof),
        .ev_bus_reset (ev_bus_reset),
        .ev_esusp     (ev_esusp),
        .ev_error     (ev_error),
        .xfer_done    (xfer_done),
        .xfer_refused (xfer_refused),
        .ev_dma_late  (ev_dma_late),
        .susp_pulse   (susp_pulse),
        .set_vec      (set_vec)
    );

    usb_flag_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .flags   (flags)
    );

    assign rd_data = flags;
    assign irq     = |flags;
endmodule

// File: rtl/usb_irq_checker.sv
module usb_irq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_sof,
    input logic       ev_bus_reset,
    input logic       ev_esusp,
    input logic       ev_error,
    input logic       xfer_done,
    input logic       ev_dma_late,
    input logic       force_susp,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       irq
);
    logic quiet;
    assign quiet = !(ev_sof || ev_bus_reset || ev_esusp || ev_error
                     || xfer_done || ev_dma_late);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |-> (rd_data == 8'h00));

    p_no_sw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && quiet) |=> ((rd_data & ~$past(rd_data)) == 8'h00));

    p_clear_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && quiet) |=> (rd_data == ($past(rd_data) & $past(wr_data))));

    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sof && wr_en && !wr_data[0]) |=> rd_data[0]);

    p_ovr_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_error && rd_data[4]) |=> rd_data[3]);

    p_ovr_sof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sof && rd_data[0]) |=> rd_data[3]);

    p_forced_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        force_susp |=> !$rose(rd_data[7]));

    p_irq_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (rd_data != 8'h00));
endmodule

bind usb_irq_status usb_irq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ev_sof       (ev_sof),
    .ev_bus_reset (ev_bus_reset),
    .ev_esusp     (ev_esusp),
    .ev_error     (ev_error),
    .xfer_done    (xfer_done),
    .ev_dma_late  (ev_dma_late),
    .force_susp   (force_susp),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rd_data      (rd_data),
    .irq          (irq)
);

// File: tb/usb_irq_status_test.sv
module usb_irq_status_test;
    localparam int CLK_HZ  = 100_000;
    localparam int IDLE_US = 3000;
    localparam int LIMIT   = (CLK_HZ / 1000) * IDLE_US / 1000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_sof = 0, ev_bus_reset = 0, ev_esusp = 0, ev_error = 0;
    logic xfer_done = 0, xfer_refused = 0, ev_dma_late = 0;
    logic bus_idle = 0, force_susp = 0, resume_done = 0;
    logic wr_en = 0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    usb_irq_status #(.CLK_HZ(CLK_HZ), .IDLE_US(IDLE_US)) uut (
        .clk(clk), .rst_n(rst_n),
        .ev_sof(ev_sof), .ev_bus_reset(ev_bus_reset), .ev_esusp(ev_esusp),
        .ev_error(ev_error), .xfer_done(xfer_done), .xfer_refused(xfer_refused),
        .ev_dma_late(ev_dma_late), .bus_idle(bus_idle), .force_susp(force_susp),
        .resume_done(resume_done), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1; wr_data = v;
        @(negedge clk);
        wr_en = 0; wr_data = 8'h00;
    endtask

    task automatic test_reset();
        check("R1 flags in reset", rd_data, 8'h00);
        check("R1 irq in reset", {7'b0, irq}, 8'h00);
        @(negedge clk); rst_n = 1;
        tick(2);
        check("R1 flags after reset", rd_data, 8'h00);
    endtask

    task automatic test_positions();
        @(negedge clk); ev_sof = 1;       @(negedge clk); ev_sof = 0;
        check("R2 frame start bit0", rd_data, 8'h01);
        check("R11 irq high", {7'b0, irq}, 8'h01);
        @(negedge clk); ev_esusp = 1;     @(negedge clk); ev_esusp = 0;
        check("R2 expected suspend bit2", rd_data, 8'h05);
        @(negedge clk); ev_error = 1;     @(negedge clk); ev_error = 0;
        check("R2 error bit4", rd_data, 8'h15);
        @(negedge clk); ev_dma_late = 1;  @(negedge clk); ev_dma_late = 0;
        check("R2 dma bit6", rd_data, 8'h55);
        write_reg(8'h00);
        check("R4 clear all", rd_data, 8'h00);
        check("R11 irq low", {7'b0, irq}, 8'h00);
    endtask

    task automatic test_write_rules();
        write_reg(8'hFF);
        check("R3 write ones sets nothing", rd_data, 8'h00);
        @(negedge clk); ev_sof = 1; ev_esusp = 1; ev_dma_late = 1;
        @(negedge clk); ev_sof = 0; ev_esusp = 0; ev_dma_late = 0;
        check("R2 three events", rd_data, 8'h45);
        write_reg(8'hFB);
        check("R4 selective clear bit2", rd_data, 8'h41);
        @(negedge clk); ev_dma_late = 1; wr_en = 1; wr_data = 8'h00;
        @(negedge clk); ev_dma_late = 0; wr_en = 0;
        check("R5 set beats clear", rd_data, 8'h40);
        write_reg(8'h00);
    endtask

    task automatic test_overrun();
        @(negedge clk); ev_error = 1; @(negedge clk); ev_error = 0;
        check("R6 first error no overrun", rd_data, 8'h10);
        @(negedge clk); ev_error = 1; @(negedge clk); ev_error = 0;
        check("R6 repeated error overrun", rd_data, 8'h18);
        write_reg(8'h00);
        @(negedge clk); ev_sof = 1; @(negedge clk); ev_sof = 0;
        check("R6 first frame no overrun", rd_data, 8'h01);
        @(negedge clk); ev_sof = 1; wr_en = 1; wr_data = 8'hFE;
        @(negedge clk); ev_sof = 0; wr_en = 0;
        check("R6 repeat frame while clearing", rd_data, 8'h09);
        write_reg(8'h00);
    endtask

    task automatic test_transfer();
        @(negedge clk); xfer_done = 1; xfer_refused = 1;
        @(negedge clk); xfer_done = 0; xfer_refused = 0;
        check("R7 refused transfer ignored", rd_data, 8'h00);
        @(negedge clk); xfer_done = 1;
        @(negedge clk); xfer_done = 0;
        check("R7 good transfer bit5", rd_data, 8'h20);
        write_reg(8'h00);
    endtask

    task automatic test_idle();
        @(negedge clk); bus_idle = 1;
        tick(LIMIT + 20);
        check("R8 unarmed idle ignored", rd_data, 8'h00);
        @(negedge clk); bus_idle = 0; ev_bus_reset = 1;
        @(negedge clk); ev_bus_reset = 0;
        check("R2 bus reset bit1", rd_data, 8'h02);
        write_reg(8'h00);
        bus_idle = 1;
        tick(LIMIT - 1);
        check("R8 one cycle short", rd_data, 8'h00);
        tick(1);
        check("R8 suspend at limit", rd_data, 8'h80);
        write_reg(8'h00);
        tick(LIMIT + 5);
        check("R8 no second suspend while idle", rd_data, 8'h00);
        bus_idle = 0;
        @(negedge clk); bus_idle = 1;
        tick(LIMIT - 50);
        bus_idle = 0;
        @(negedge clk); bus_idle = 1;
        tick(LIMIT - 1);
        check("R9 activity restarts count", rd_data, 8'h00);
        tick(1);
        check("R9 suspend after restart", rd_data, 8'h80);
        bus_idle = 0;
        write_reg(8'h00);
    endtask

    task automatic test_forced();
        @(negedge clk); force_susp = 1; bus_idle = 1;
        tick(LIMIT + 10);
        check("R10 blocked while forced", rd_data, 8'h00);
        force_susp = 0;
        tick(LIMIT + 10);
        check("R10 blocked until resume", rd_data, 8'h00);
        bus_idle = 0;
        @(negedge clk); resume_done = 1;
        @(negedge clk); resume_done = 0; bus_idle = 1;
        tick(LIMIT - 1);
        check("R10 resumed one short", rd_data, 8'h00);
        tick(1);
        check("R10 suspend after resume", rd_data, 8'h80);
        bus_idle = 0;
        write_reg(8'h00);
    endtask

    initial begin
        tick(3);
        test_reset();
        test_positions();
        test_write_rules();
        test_overrun();
        test_transfer();
        test_idle();
        test_forced();
        tick(3);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule